// File: doc/BRIEF.md
# Time-Slotted Static Path Relay Mesh

This block is a small rectangular mesh of relay nodes that moves one bit per connection along paths fixed ahead of time. Every path is a chain of hops through neighbouring nodes. Each hop is tied to one slot of a repeating frame of `SLOTS` steps. No node holds an address. Each node keeps a table indexed by slot number. An entry says whether a bit starts at this node in that slot, which neighbour to push a bit toward, and whether a bit arriving in that slot ends its journey here. During a frame, every node acts only on the entry for the current slot index. It launches its own source bit, relays the bit it received one slot earlier, or keeps an arriving bit as delivered.

A host fills the tables through a valid/ready write port. The port takes a write only between frames: `cfg_ready` is low for the whole frame, and a host must hold `cfg_valid` and the write fields steady until it sees `cfg_ready` high at a clock edge. The host presents one source bit per node and pulses `frame_start`. It waits for `frame_done`, then reads the delivered bits, one per node and slot. Per-direction link enables mark which physical links may be used. A bit sent over a missing or disabled link, or toward no direction at all, is lost and raises a sticky error.

Top module: `slot_relay_mesh`

## Requirements
- R1: After reset every slot entry has start clear, end clear and direction FREE. `dlv_bits`, `route_err`, `busy` and `frame_done` are 0, and `cfg_ready` is 1.
- R2: A table write takes effect at a clock edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low in every cycle where `busy` is high.
- R3: A `frame_start` sampled high while idle starts a frame. `busy` is high for exactly `SLOTS` cycles, handling slot 0 through slot `SLOTS`-1 in order. `frame_done` is high for the single cycle after the last slot. A `frame_start` seen while busy is ignored.
- R4: In slot s, a node whose entry s has start set sends its source bit toward the direction in entry s.
- R5: A bit received in slot s at a node whose entry s has end clear is sent on in slot s+1, toward the direction in entry s+1. Separate receive and send state let a node receive one bit and send another in the same slot, including both ways over one link.
- R6: A bit received in slot s at a node whose entry s has end set is kept as delivered bit `dlv_bits[node*SLOTS + s]`.
- R7: Delivered bits hold their value after `frame_done` until the next accepted `frame_start`. At that edge they all clear to 0.
- R8: A send toward a direction with no physical neighbour, or whose `link_en[node*4 + dir]` bit is 0, reaches no node. It sets `route_err`, which stays 1 until reset.
- R9: A node with a bit to send whose entry direction is FREE drops the bit and sets `route_err`.
- R10: When no node sends or receives more than one bit in any slot, every path delivers its start node's bit and `route_err` stays 0.
- R11: Source bits are captured at the accepted `frame_start`. Later changes to `src_bits` have no effect during that frame.
- R12: Direction code 0 is north (row-1), 1 is east (col+1), 2 is south (row+1) and 3 is west (col-1). Codes 4 to 7 mean FREE. The node number is row*COLS+col, with row 0 at the north edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Table write request |
| cfg_ready | output | 1 | Write port can accept (idle) |
| cfg_node | input | NODE_W | Node number of the write |
| cfg_slot | input | SLOT_W | Slot index of the write |
| cfg_start | input | 1 | Start flag for the entry |
| cfg_dir | input | 3 | Direction code for the entry |
| cfg_end | input | 1 | End flag for the entry |
| link_en | input | NODES*4 | Link enable, bit node*4+dir |
| src_bits | input | NODES | Source bit per node |
| frame_start | input | 1 | Frame start pulse |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| dlv_bits | output | NODES*SLOTS | Delivered bits, bit node*SLOTS+slot |
| route_err | output | 1 | Sticky drop error |

## Verification
The edge that accepts `frame_start` clears the delivered bits. The slot-s results are registered at edge s+1 after it. `busy` is therefore seen for `SLOTS` falling edges and `frame_done` on falling edge `SLOTS`+1, and the bench counts falling edges from the accept to check this. All data checks sample at falling edges once `frame_done` is seen, except the clearing check, which samples one falling edge after the accept. Expected delivered vectors come from a bench model that places random, conflict-free paths and records which start node's captured bit each end slot should hold.

// File: rtl/slot_relay_pkg.sv
package slot_relay_pkg;
  localparam int NUM_DIRS = 4;
  localparam logic [2:0] DIR_N    = 3'd0;
  localparam logic [2:0] DIR_E    = 3'd1;
  localparam logic [2:0] DIR_S    = 3'd2;
  localparam logic [2:0] DIR_W    = 3'd3;
  localparam logic [2:0] DIR_FREE = 3'd7;

  typedef struct packed {
    logic       start_f;
    logic [2:0] dir;
    logic       end_f;
  } slot_ent_t;

  localparam slot_ent_t ENT_IDLE = '{start_f: 1'b0, dir: DIR_FREE, end_f: 1'b0};

  function automatic logic dir_is_link(input logic [2:0] d);
    return (d[2] == 1'b0);
  endfunction
endpackage

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  output logic              go,
  output logic              run,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              done
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic              done_q;

  assign go       = frame_start & ~run_q;
  assign run      = run_q;
  assign slot_idx = slot_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q && (slot_q == LAST);
      if (go) begin
        run_q  <= 1'b1;
        slot_q <= '0;
      end else if (run_q) begin
        if (slot_q == LAST) begin
          run_q  <= 1'b0;
          slot_q <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  // R3: last slot is followed by a single done cycle with the frame closed
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && slot_q == LAST) |=> (done_q && !run_q));

  // R3: inner slots advance by one each cycle
  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && slot_q != LAST) |=> (run_q && slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/relay_node.sv
module relay_node
  import slot_relay_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  slot_ent_t         cfg_ent,
  input  logic              go,
  input  logic              run,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              src_bit,
  input  logic [NUM_DIRS-1:0] link_ok,
  input  logic              rx_valid,
  input  logic              rx_bit,
  output logic              tx_valid,
  output logic [1:0]        tx_dir,
  output logic              tx_bit,
  output logic [SLOTS-1:0]  dlv,
  output logic              err
);
  slot_ent_t        tbl [SLOTS];
  slot_ent_t        ent;
  logic             active_q;
  logic             outbox_q;
  logic             src_q;
  logic [SLOTS-1:0] dlv_q;
  logic             err_q;
  logic             send;
  logic             dir_ok;
  logic             take;

  assign ent      = tbl[slot_idx];
  assign send     = run & (ent.start_f | active_q);
  assign dir_ok   = dir_is_link(ent.dir) && link_ok[ent.dir[1:0]];
  assign tx_valid = send & dir_ok;
  assign tx_dir   = ent.dir[1:0];
  assign tx_bit   = ent.start_f ? src_q : outbox_q;
  assign take     = run & rx_valid;
  assign dlv      = dlv_q;
  assign err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) tbl[i] <= ENT_IDLE;
    end else if (cfg_we) begin
      tbl[cfg_slot] <= cfg_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      outbox_q <= 1'b0;
      src_q    <= 1'b0;
      dlv_q    <= '0;
    end else if (go) begin
      active_q <= 1'b0;
      src_q    <= src_bit;
      dlv_q    <= '0;
    end else if (run) begin
      if (take && !ent.end_f) begin
        outbox_q <= rx_bit;
        active_q <= 1'b1;
      end else if (send) begin
        active_q <= 1'b0;
      end
      if (take && ent.end_f) dlv_q[slot_idx] <= rx_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               err_q <= 1'b0;
    else if (send && !dir_ok) err_q <= 1'b1;
  end

  // R7: delivered bits move only on a frame start or an end-slot arrival
  assert_dlv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !(take && ent.end_f)) |=> $stable(dlv_q));

  // R8: error flag never falls once raised
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: an unusable direction with a pending bit raises the error
  assert_drop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !dir_ok) |=> err_q);

  // R10: a launch never coincides with a pending relay in the same slot
  assert_single_leave_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !(ent.start_f && active_q));
endmodule

// File: rtl/slot_relay_mesh.sv
module slot_relay_mesh
  import slot_relay_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int SLOTS  = 8,
  parameter int NODES  = ROWS * COLS,
  parameter int NODE_W = $clog2(NODES),
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_valid,
  output logic                      cfg_ready,
  input  logic [NODE_W-1:0]         cfg_node,
  input  logic [SLOT_W-1:0]         cfg_slot,
  input  logic                      cfg_start,
  input  logic [2:0]                cfg_dir,
  input  logic                      cfg_end,
  input  logic [NODES*NUM_DIRS-1:0] link_en,
  input  logic [NODES-1:0]          src_bits,
  input  logic                      frame_start,
  output logic                      busy,
  output logic                      frame_done,
  output logic [NODES*SLOTS-1:0]    dlv_bits,
  output logic                      route_err
);
  logic              go;
  logic              run;
  logic [SLOT_W-1:0] slot_idx;
  logic              cfg_fire;
  slot_ent_t         cfg_ent;

  logic             tx_valid [NODES];
  logic [1:0]       tx_dir   [NODES];
  logic             tx_bit   [NODES];
  logic [NODES-1:0] err_vec;

  assign cfg_ready = ~run;
  assign busy      = run;
  assign cfg_fire  = cfg_valid & cfg_ready;
  assign cfg_ent   = '{start_f: cfg_start, dir: cfg_dir, end_f: cfg_end};
  assign route_err = |err_vec;

  frame_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .go         (go),
    .run        (run),
    .slot_idx   (slot_idx),
    .done       (frame_done)
  );

  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int R = n / COLS;
    localparam int C = n % COLS;
    localparam logic [NUM_DIRS-1:0] PHYS = {C > 0, R < ROWS - 1, C < COLS - 1, R > 0};

    logic [NUM_DIRS-1:0] hit;
    logic [NUM_DIRS-1:0] hbit;
    logic [NUM_DIRS-1:0] lok;
    logic                rx_valid;
    logic                rx_bit;

    if (R > 0) begin : g_from_n
      assign hit[0]  = tx_valid[n-COLS] && (tx_dir[n-COLS] == DIR_S[1:0]);
      assign hbit[0] = tx_bit[n-COLS];
    end else begin : g_no_n
      assign hit[0]  = 1'b0;
      assign hbit[0] = 1'b0;
    end
    if (C < COLS - 1) begin : g_from_e
      assign hit[1]  = tx_valid[n+1] && (tx_dir[n+1] == DIR_W[1:0]);
      assign hbit[1] = tx_bit[n+1];
    end else begin : g_no_e
      assign hit[1]  = 1'b0;
      assign hbit[1] = 1'b0;
    end
    if (R < ROWS - 1) begin : g_from_s
      assign hit[2]  = tx_valid[n+COLS] && (tx_dir[n+COLS] == DIR_N[1:0]);
      assign hbit[2] = tx_bit[n+COLS];
    end else begin : g_no_s
      assign hit[2]  = 1'b0;
      assign hbit[2] = 1'b0;
    end
    if (C > 0) begin : g_from_w
      assign hit[3]  = tx_valid[n-1] && (tx_dir[n-1] == DIR_E[1:0]);
      assign hbit[3] = tx_bit[n-1];
    end else begin : g_no_w
      assign hit[3]  = 1'b0;
      assign hbit[3] = 1'b0;
    end

    assign lok      = PHYS & link_en[n*NUM_DIRS +: NUM_DIRS];
    assign rx_valid = |hit;
    assign rx_bit   = |(hit & hbit);

    relay_node #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_node (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_fire && (cfg_node == NODE_W'(n))),
      .cfg_slot(cfg_slot),
      .cfg_ent (cfg_ent),
      .go      (go),
      .run     (run),
      .slot_idx(slot_idx),
      .src_bit (src_bits[n]),
      .link_ok (lok),
      .rx_valid(rx_valid),
      .rx_bit  (rx_bit),
      .tx_valid(tx_valid[n]),
      .tx_dir  (tx_dir[n]),
      .tx_bit  (tx_bit[n]),
      .dlv     (dlv_bits[n*SLOTS +: SLOTS]),
      .err     (err_vec[n])
    );

    // R10: at most one neighbour drives into this node in any slot
    assert_one_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ($countones(hit) <= 1));
  end
endmodule

// File: tb/slot_relay_mesh_tb.sv
module slot_relay_mesh_tb;
  localparam int ROWS = 4, COLS = 4, SLOTS = 8;
  localparam int NODES = ROWS * COLS;
  localparam int NW = $clog2(NODES), SW = $clog2(SLOTS);
  localparam int DV = NODES * SLOTS;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, cfg_ready;
  logic [NW-1:0] cfg_node = '0;
  logic [SW-1:0] cfg_slot = '0;
  logic cfg_start = 0, cfg_end = 0;
  logic [2:0] cfg_dir = 3'd7;
  logic [NODES*4-1:0] link_en = '1;
  logic [NODES-1:0] src_bits = '0;
  logic frame_start = 0, busy, frame_done, route_err;
  logic [DV-1:0] dlv_bits;

  int n_chk = 0, n_fail = 0;

  bit       t_start [NODES][SLOTS];
  bit [2:0] t_dir   [NODES][SLOTS];
  bit       t_end   [NODES][SLOTS];
  bit       lv      [NODES][SLOTS];
  bit       en      [NODES][SLOTS];
  logic [DV-1:0]    exp_dlv;
  logic [NODES-1:0] srcv;

  always #4 clk = ~clk;

  slot_relay_mesh #(.ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_node(cfg_node), .cfg_slot(cfg_slot), .cfg_start(cfg_start),
    .cfg_dir(cfg_dir), .cfg_end(cfg_end), .link_en(link_en), .src_bits(src_bits),
    .frame_start(frame_start), .busy(busy), .frame_done(frame_done),
    .dlv_bits(dlv_bits), .route_err(route_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DV-1:0] act, input logic [DV-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic int nbr(input int n, input int d);
    int r = n / COLS, c = n % COLS;
    case (d)
      0: return (r > 0) ? n - COLS : -1;
      1: return (c < COLS - 1) ? n + 1 : -1;
      2: return (r < ROWS - 1) ? n + COLS : -1;
      default: return (c > 0) ? n - 1 : -1;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; link_en = '1; frame_start = 0; cfg_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cfg_write(input int n, input int s, input bit st, input bit [2:0] d, input bit e);
    @(negedge clk);
    cfg_valid = 1; cfg_node = NW'(n); cfg_slot = SW'(s);
    cfg_start = st; cfg_dir = d; cfg_end = e;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  // returns falling edges from accept until frame_done seen; scrambles src during frame
  task automatic run_frame(output int cyc);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    src_bits = NODES'($urandom);
    cyc = 1;
    while (!frame_done && cyc < 40) begin
      @(negedge clk); cyc++;
      src_bits = NODES'($urandom);
    end
  endtask

  task automatic clear_model();
    for (int n = 0; n < NODES; n++)
      for (int s = 0; s < SLOTS; s++) begin
        t_start[n][s] = 0; t_dir[n][s] = 3'd7; t_end[n][s] = 0;
        lv[n][s] = 0; en[n][s] = 0;
      end
    exp_dlv = '0;
  endtask

  task automatic place(input int src, input int s0, input int len);
    int pn[8]; int pd[8]; int cur; bit ok;
    cur = src; ok = 1;
    for (int k = 0; k < len && ok; k++) begin
      int d0, pick, nx;
      pick = -1; nx = -1;
      if (s0 + k >= SLOTS) begin ok = 0; break; end
      d0 = $urandom_range(0, 3);
      for (int t = 0; t < 4 && pick < 0; t++) begin
        int dd = (d0 + t) % 4;
        int cand = nbr(cur, dd);
        if (cand >= 0 && !lv[cur][s0+k] && !en[cand][s0+k]) begin pick = dd; nx = cand; end
      end
      if (pick < 0) ok = 0;
      else begin pn[k] = cur; pd[k] = pick; cur = nx; end
    end
    if (ok) begin
      cur = src;
      for (int k = 0; k < len; k++) begin
        int nx = nbr(pn[k], pd[k]);
        if (k == 0) t_start[pn[k]][s0] = 1;
        t_dir[pn[k]][s0+k] = 3'(pd[k]);
        lv[pn[k]][s0+k] = 1;
        en[nx][s0+k] = 1;
        if (k == len - 1) begin
          t_end[nx][s0+k] = 1;
          exp_dlv[nx*SLOTS + s0 + k] = srcv[src];
        end
      end
    end
  endtask

  task automatic load_model();
    for (int n = 0; n < NODES; n++)
      for (int s = 0; s < SLOTS; s++)
        if (t_start[n][s] || t_end[n][s] || t_dir[n][s] != 3'd7)
          cfg_write(n, s, t_start[n][s], t_dir[n][s], t_end[n][s]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [DV-1:0] e;
    void'($urandom(32'h5A17));
    do_reset();

    // R1 reset state
    @(negedge clk);
    chk(dlv_bits == '0, "R1", "dlv after reset", dlv_bits, '0);
    chk({busy, frame_done, route_err, cfg_ready} == 4'b0001, "R1", "flags after reset",
        DV'({busy, frame_done, route_err, cfg_ready}), DV'(4'b0001));

    // R3/R2 timing, with a stray frame_start mid-frame
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int k = 1; k <= SLOTS; k++) begin
      chk(busy && !frame_done, "R3", $sformatf("busy slot cycle %0d", k),
          DV'({busy, frame_done}), DV'(2'b10));
      chk(!cfg_ready, "R2", "cfg_ready low while busy", DV'(cfg_ready), '0);
      frame_start = (k == 3);
      @(negedge clk);
    end
    frame_start = 0;
    chk(frame_done && !busy, "R3", "done after last slot", DV'({busy, frame_done}), DV'(2'b01));
    @(negedge clk);
    chk(!frame_done && !busy, "R3", "single done, stray start ignored",
        DV'({busy, frame_done}), '0);
    chk(dlv_bits == '0, "R1", "empty tables deliver nothing", dlv_bits, '0);

    // R4 R5 R6 R10 R11 R12: 3-hop path plus opposite exchange on link 1-2
    cfg_write(0, 0, 1, 3'd1, 0);
    cfg_write(1, 1, 0, 3'd1, 1);
    cfg_write(2, 1, 1, 3'd3, 0);
    cfg_write(2, 2, 0, 3'd2, 0);
    cfg_write(6, 2, 0, 3'd7, 1);
    src_bits = '0; src_bits[0] = 1; src_bits[2] = 1;
    run_frame(cyc);
    chk(cyc == SLOTS + 1, "R3", "done edge count", DV'(cyc), DV'(SLOTS + 1));
    e = '0; e[6*SLOTS+2] = 1; e[1*SLOTS+1] = 1;
    chk(dlv_bits == e, "R5", "relay and opposite exchange (R4 R6 R11 R12)", dlv_bits, e);
    chk(!route_err, "R10", "legal paths raise no error", DV'(route_err), '0);
    repeat (5) @(negedge clk);
    chk(dlv_bits == e, "R7", "delivered bits held", dlv_bits, e);
    // second frame: R7 clear at accept, new source values
    @(negedge clk); frame_start = 1; src_bits = '0; src_bits[2] = 1;
    @(negedge clk); frame_start = 0;
    chk(dlv_bits == '0, "R7", "cleared at accepted start", dlv_bits, '0);
    while (!frame_done) @(negedge clk);
    e = '0; e[1*SLOTS+1] = 1;
    chk(dlv_bits == e, "R11", "fresh capture per frame", dlv_bits, e);

    // R8 disabled link
    do_reset();
    link_en[0*4+1] = 0;
    cfg_write(0, 0, 1, 3'd1, 0);
    cfg_write(1, 0, 0, 3'd7, 1);
    src_bits = '1;
    run_frame(cyc);
    chk(dlv_bits == '0, "R8", "disabled link delivers nothing", dlv_bits, '0);
    chk(route_err, "R8", "disabled link error", DV'(route_err), DV'(1));
    run_frame(cyc);
    chk(route_err, "R8", "error sticky", DV'(route_err), DV'(1));
    // R8 boundary: node 3 sits at east edge
    do_reset();
    cfg_write(3, 0, 1, 3'd1, 0);
    run_frame(cyc);
    chk(route_err, "R8", "east boundary error", DV'(route_err), DV'(1));

    // R9 transit bit meets FREE entry
    do_reset();
    cfg_write(0, 0, 1, 3'd1, 0);
    src_bits = '1;
    run_frame(cyc);
    chk(route_err && dlv_bits == '0, "R9", "FREE transit dropped",
        DV'(route_err) | dlv_bits, DV'(1));

    // random legal path sets
    for (int rnd = 0; rnd < 24; rnd++) begin
      do_reset();
      clear_model();
      srcv = NODES'($urandom);
      for (int p = 0; p < 14; p++)
        place($urandom_range(0, NODES - 1), $urandom_range(0, SLOTS - 2), $urandom_range(1, 4));
      load_model();
      src_bits = srcv;
      run_frame(cyc);
      chk(cyc == SLOTS + 1, "R3", "random frame length", DV'(cyc), DV'(SLOTS + 1));
      chk(dlv_bits == exp_dlv, "R6", $sformatf("random round %0d (R4 R5 R10 R11)", rnd),
          dlv_bits, exp_dlv);
      chk(!route_err, "R10", "random legal paths no error", DV'(route_err), '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule